// File: doc/BRIEF.md
# Video Switch Control Register Slave

This block is the two-wire serial slave that configures an analog video input switch. A host writes a six-byte control image through the bus. The block holds that image and turns it into decoded control fields: a source select for every video path, a mute flag for every driver path, gain and filter choices, high-impedance controls, a standby bit, four parallel port bits, four audio-switch control bits, and two three-level output modes for the scart function-switch lines. Read transactions return the same image. Spare bit positions read back as ones, and the last byte carries the current level of the two function-switch monitor inputs.

SCL and SDA are sampled with the system clock after a synchronizer, so start, stop and clock edges are events in one clock domain. Bytes that are written go into a staging copy. The live image, which drives every decoded output, takes the staged bytes only when the stop condition arrives, so a multi-byte update reaches the switch all at once. An active-low all-mute input forces every driver path into mute, whatever the image holds.

Top module: `vsw_ctrl_regs`

## Requirements
- R1: The slave answers only the 7-bit address 1001_00P, where P is the level of `addr_pin`. The write byte is therefore 90h or 92h and the read byte 91h or 93h. The block pulls SDA low in the acknowledge slot for its own address only, and stays silent on the bus for any other address until the next start.
- R2: Data bytes that follow a write address go to byte positions 0, 1, 2, ... in order. The block acknowledges each of the first six.
- R3: Written bytes change no decoded output before the stop condition. At the stop, every byte written since the last stop takes effect together.
- R4: After reset the image is B0=20h, B1=05h, B2=00h, B3=00h, B4=09h, B5=00h. So the AD-path select is 001, the audio-switch bits `asw_o` are 1001 (bits 0 and 3 high), the parallel bits are 0, and both FS modes are 00 (input mode).
- R5: A read returns B0..B5 in order. Spare positions read as 1: B0 bits 1:0, B2 bit 0 and B3 bits 4:0.
- R6: In read data, bits 3:2 of B5 carry `fs1_lvl` and bits 1:0 carry `fs2_lvl`, as they stand when that byte is loaded for transmission (00 low, 10 mid, 11 high). Bits 7:4 of B5 read back as written.
- R7: A seventh or later data byte in a write is not acknowledged and changes nothing. A read that goes past B5 returns FFh.
- R8: A repeated start sets the byte position back to 0. Bytes staged before it stay pending until the stop.
- R9: `path_mute` bits are [0] AD path, [1] L1 CVBS/Y, [2] AUX CVBS/Y, [3] AUX C, [4] R/C, [5] G/B. The AD path mutes for codes 101..111. Every other path mutes when the top bit of its code is set. While `mute_all_n` is low, all six bits are 1.
- R10: Field positions: B0[7:5] AD select, B0[4:2] AUX CVBS/Y select; B1[7:6] L1 CVBS/Y, B1[5:4] AUX C, B1[3:2] R/C, B1[1:0] G/B; B2[7:6] VPS/PDC source, B2[5] encoder gain 8 dB (2 dB on the AD path), B2[4] VPS gain 6 dB, B2[3] RGB filter, B2[2] R/C bias mode, B2[1] R/C encoder RGB choice; B3[7] AUX C high-Z, B3[6] B high-Z, B3[5] standby; B4[7:4] parallel bits 3..0, B4[3:0] audio-switch bits 3..0; B5[7:6] L1 FS mode, B5[5:4] AUX FS mode.
- R11: SDA is taken on the rising edge of SCL. The block changes its SDA drive only after a falling edge of SCL, and releases SDA after every start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| addr_pin | input | 1 | Address select pin, bit 0 of the 7-bit address |
| mute_all_n | input | 1 | Low forces every driver path to mute |
| fs1_lvl | input | 2 | Current level code of function-switch monitor 1 |
| fs2_lvl | input | 2 | Current level code of function-switch monitor 2 |
| adc_src | output | 3 | AD path source code |
| auxy_src | output | 3 | AUX CVBS/Y source code |
| l1y_src | output | 2 | L1 CVBS/Y source code |
| auxc_src | output | 2 | AUX chroma source code |
| rc_src | output | 2 | R/C output source code |
| gb_src | output | 2 | G and B output source code |
| vps_src | output | 2 | VPS/PDC output source code |
| path_mute | output | 6 | Mute flag per driver path |
| enc_gain8 | output | 1 | Encoder paths at the higher gain |
| vps_gain6 | output | 1 | VPS/PDC buffer at 6 dB |
| lpf_en | output | 1 | RGB outputs through the filter |
| rc_bias | output | 1 | R/C input uses resistive bias instead of clamp |
| rc_enc_rgb | output | 1 | R/C encoder source is red instead of chroma |
| auxc_hiz | output | 1 | AUX chroma output high impedance |
| b_hiz | output | 1 | B output high impedance |
| standby | output | 1 | Standby mode |
| par_o | output | 4 | Parallel port bits |
| asw_o | output | 4 | Audio-switch control bits |
| fsl_mode | output | 2 | L1 function-switch output mode |
| fsa_mode | output | 2 | AUX function-switch output mode |

## Verification
The hardest case to reach is a write that has been staged but not yet committed, since the ports show nothing until the stop. The bench sends all six bytes, holds SCL low without a stop, and compares every decoded output with the old image. It then issues the stop and compares again. It also reaches the repeated-start case by sending a byte, restarting to the same address and writing position 0 again within one transaction. A sweep of every address byte checks that the acknowledge slot is pulled low only for the two addresses that match.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

  localparam int VSW_NBYTES = 6;
  localparam int VSW_IDXW   = 3;

  typedef logic [VSW_NBYTES-1:0][7:0] vsw_image_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } vsw_state_e;

  // Power-on content of each image byte.
  function automatic logic [7:0] vsw_reset_byte(input logic [VSW_IDXW-1:0] k);
    case (k)
      3'd0:    return 8'h20;
      3'd1:    return 8'h05;
      3'd4:    return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  // Bit positions without a function, forced to one on read.
  function automatic logic [7:0] vsw_spare_mask(input logic [VSW_IDXW-1:0] k);
    case (k)
      3'd0:    return 8'h03;
      3'd2:    return 8'h01;
      3'd3:    return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] vsw_readback(input vsw_image_t img,
                                              input logic [VSW_IDXW-1:0] sel,
                                              input logic [1:0] fs1,
                                              input logic [1:0] fs2);
    logic [7:0] b;
    if (sel >= VSW_IDXW'(VSW_NBYTES)) return 8'hFF;
    b = img[sel] | vsw_spare_mask(sel);
    if (sel == VSW_IDXW'(VSW_NBYTES - 1)) b[3:0] = {fs1, fs2};
    return b;
  endfunction

  // The AD path uses codes 0..4 as sources, the rest mute.
  function automatic logic vsw_adc_muted(input logic [2:0] code);
    return code > 3'd4;
  endfunction

endpackage

// File: rtl/vsw_line_sync.sv
module vsw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/vsw_i2c_engine.sv
module vsw_i2c_engine
  import vsw_pkg::*;
#(
  parameter logic [5:0] ADDR_BASE = 6'b100100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_evt,
  input  logic                stop_evt,
  input  logic                addr_pin,
  input  logic [7:0]          rd_byte,
  output logic [VSW_IDXW-1:0] rd_sel,
  output logic                sda_pull,
  output logic                wr_stb,
  output logic [VSW_IDXW-1:0] wr_idx,
  output logic [7:0]          wr_byte,
  output logic                commit_stb
);
  localparam logic [VSW_IDXW-1:0] END_IDX = VSW_IDXW'(VSW_NBYTES);

  vsw_state_e          state;
  logic [3:0]          bitcnt;
  logic [7:0]          shreg;
  logic [VSW_IDXW-1:0] idx;
  logic                rw, wr_sess, mack;
  logic                addr_match;

  assign addr_match = (shreg[7:1] == {ADDR_BASE, addr_pin});
  assign rd_sel     = (state == ST_RACK) ? idx + 1'b1 : idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0; idx <= '0;
      rw <= 1'b0; wr_sess <= 1'b0; mack <= 1'b1; sda_pull <= 1'b0;
      wr_stb <= 1'b0; wr_idx <= '0; wr_byte <= '0; commit_stb <= 1'b0;
    end else begin
      wr_stb     <= 1'b0;
      commit_stb <= 1'b0;
      if (start_evt) begin
        state <= ST_ADDR; bitcnt <= '0; idx <= '0; sda_pull <= 1'b0;
      end else if (stop_evt) begin
        state <= ST_IDLE; sda_pull <= 1'b0;
        commit_stb <= wr_sess;
        wr_sess <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (addr_match) begin
                state <= ST_AACK; sda_pull <= 1'b1; rw <= shreg[0];
                if (!shreg[0]) wr_sess <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              state <= ST_RDAT; shreg <= rd_byte; sda_pull <= ~rd_byte[7];
            end else begin
              state <= ST_WDAT; sda_pull <= 1'b0;
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (idx < END_IDX) begin
                wr_stb <= 1'b1; wr_idx <= idx; wr_byte <= shreg; sda_pull <= 1'b1;
              end
              state <= ST_WACK;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_pull <= 1'b0; bitcnt <= '0; state <= ST_WDAT;
            if (idx < END_IDX) idx <= idx + 1'b1;
          end
          ST_RDAT: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_pull <= 1'b0; bitcnt <= '0; state <= ST_RACK;
            end else begin
              shreg <= {shreg[6:0], 1'b1}; sda_pull <= ~shreg[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= sda_s;
            else if (scl_fall) begin
              if (!mack) begin
                state <= ST_RDAT; shreg <= rd_byte; sda_pull <= ~rd_byte[7];
                if (idx < END_IDX) idx <= idx + 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vsw_reg_image.sv
module vsw_reg_image
  import vsw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [VSW_IDXW-1:0] wr_idx,
  input  logic [7:0]          wr_byte,
  input  logic                commit_stb,
  input  logic [VSW_IDXW-1:0] rd_sel,
  input  logic [1:0]          fs1_lvl,
  input  logic [1:0]          fs2_lvl,
  output vsw_image_t          live_img,
  output logic [7:0]          rd_byte
);
  vsw_image_t stage_img;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < VSW_NBYTES; i++) begin
        stage_img[i] <= vsw_reset_byte(VSW_IDXW'(i));
        live_img[i]  <= vsw_reset_byte(VSW_IDXW'(i));
      end
    end else begin
      if (wr_stb) stage_img[wr_idx] <= wr_byte;
      if (commit_stb) live_img <= stage_img;
    end
  end

  assign rd_byte = vsw_readback(live_img, rd_sel, fs1_lvl, fs2_lvl);
endmodule

// File: rtl/vsw_ctrl_regs.sv
module vsw_ctrl_regs
  import vsw_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_BASE   = 6'b100100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       addr_pin,
  input  logic       mute_all_n,
  input  logic [1:0] fs1_lvl,
  input  logic [1:0] fs2_lvl,
  output logic [2:0] adc_src,
  output logic [2:0] auxy_src,
  output logic [1:0] l1y_src,
  output logic [1:0] auxc_src,
  output logic [1:0] rc_src,
  output logic [1:0] gb_src,
  output logic [1:0] vps_src,
  output logic [5:0] path_mute,
  output logic       enc_gain8,
  output logic       vps_gain6,
  output logic       lpf_en,
  output logic       rc_bias,
  output logic       rc_enc_rgb,
  output logic       auxc_hiz,
  output logic       b_hiz,
  output logic       standby,
  output logic [3:0] par_o,
  output logic [3:0] asw_o,
  output logic [1:0] fsl_mode,
  output logic [1:0] fsa_mode
);
  logic                sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic                wr_stb, commit_stb;
  logic [VSW_IDXW-1:0] wr_idx, rd_sel;
  logic [7:0]          wr_byte, rd_byte;
  vsw_image_t          live_img;
  logic [5:0]          code_mute;

  vsw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  vsw_i2c_engine #(.ADDR_BASE(ADDR_BASE)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_pin(addr_pin), .rd_byte(rd_byte), .rd_sel(rd_sel),
    .sda_pull(sda_pull_o), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .commit_stb(commit_stb));

  vsw_reg_image u_img (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .commit_stb(commit_stb), .rd_sel(rd_sel),
    .fs1_lvl(fs1_lvl), .fs2_lvl(fs2_lvl), .live_img(live_img),
    .rd_byte(rd_byte));

  assign adc_src    = live_img[0][7:5];
  assign auxy_src   = live_img[0][4:2];
  assign l1y_src    = live_img[1][7:6];
  assign auxc_src   = live_img[1][5:4];
  assign rc_src     = live_img[1][3:2];
  assign gb_src     = live_img[1][1:0];
  assign vps_src    = live_img[2][7:6];
  assign enc_gain8  = live_img[2][5];
  assign vps_gain6  = live_img[2][4];
  assign lpf_en     = live_img[2][3];
  assign rc_bias    = live_img[2][2];
  assign rc_enc_rgb = live_img[2][1];
  assign auxc_hiz   = live_img[3][7];
  assign b_hiz      = live_img[3][6];
  assign standby    = live_img[3][5];
  assign par_o      = live_img[4][7:4];
  assign asw_o      = live_img[4][3:0];
  assign fsl_mode   = live_img[5][7:6];
  assign fsa_mode   = live_img[5][5:4];

  assign code_mute = {gb_src[1], rc_src[1], auxc_src[1], auxy_src[2],
                      l1y_src[1], vsw_adc_muted(adc_src)};
  assign path_mute = code_mute | {6{~mute_all_n}};
endmodule

// File: rtl/vsw_ctrl_regs_chk.sv
module vsw_ctrl_regs_chk
  import vsw_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                mute_all_n,
  input logic [5:0]          path_mute,
  input logic                start_evt,
  input logic                stop_evt,
  input logic                commit_stb,
  input logic                wr_stb,
  input logic [VSW_IDXW-1:0] wr_idx,
  input logic                sda_pull_o,
  input vsw_image_t          live_img
);
  // R9: all-mute input overrides every path
  assert_all_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_all_n |-> &path_mute);

  // R3: commit only follows a stop condition
  assert_commit_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> $past(stop_evt));

  // R3: live image holds between commits
  assert_image_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_stb |=> $stable(live_img));

  // R7: staged writes never go past the sixth byte
  assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_idx < VSW_IDXW'(VSW_NBYTES)));

  // R11: data line released after every start
  assert_release_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull_o);
endmodule

bind vsw_ctrl_regs vsw_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mute_all_n(mute_all_n), .path_mute(path_mute),
  .start_evt(start_evt), .stop_evt(stop_evt), .commit_stb(commit_stb),
  .wr_stb(wr_stb), .wr_idx(wr_idx), .sda_pull_o(sda_pull_o),
  .live_img(live_img));

// File: tb/vsw_ctrl_regs_tb.sv
`timescale 1ns/1ps
module vsw_ctrl_regs_tb;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_pin = 1'b0, mute_all_n = 1'b1;
  logic [1:0] fs1_lvl = 2'b10, fs2_lvl = 2'b11;
  logic sda_pull_o, sda_line;
  logic [2:0] adc_src, auxy_src;
  logic [1:0] l1y_src, auxc_src, rc_src, gb_src, vps_src, fsl_mode, fsa_mode;
  logic [5:0] path_mute;
  logic enc_gain8, vps_gain6, lpf_en, rc_bias, rc_enc_rgb, auxc_hiz, b_hiz, standby;
  logic [3:0] par_o, asw_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_img [6];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_o;

  vsw_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .addr_pin(addr_pin), .mute_all_n(mute_all_n),
    .fs1_lvl(fs1_lvl), .fs2_lvl(fs2_lvl), .adc_src(adc_src), .auxy_src(auxy_src),
    .l1y_src(l1y_src), .auxc_src(auxc_src), .rc_src(rc_src), .gb_src(gb_src),
    .vps_src(vps_src), .path_mute(path_mute), .enc_gain8(enc_gain8),
    .vps_gain6(vps_gain6), .lpf_en(lpf_en), .rc_bias(rc_bias),
    .rc_enc_rgb(rc_enc_rgb), .auxc_hiz(auxc_hiz), .b_hiz(b_hiz),
    .standby(standby), .par_o(par_o), .asw_o(asw_o), .fsl_mode(fsl_mode),
    .fsa_mode(fsa_mode));

  wire [41:0] dut_vec = {adc_src, auxy_src, l1y_src, auxc_src, rc_src, gb_src,
                         vps_src, path_mute, enc_gain8, vps_gain6, lpf_en, rc_bias,
                         rc_enc_rgb, auxc_hiz, b_hiz, standby, par_o, asw_o,
                         fsl_mode, fsa_mode};

  function automatic logic [41:0] model_vec();
    int a, ay, l, c, r, g;
    logic [5:0] m;
    a = exp_img[0] / 32;  ay = (exp_img[0] / 4) % 8;
    l = exp_img[1] / 64;  c = (exp_img[1] / 16) % 4;
    r = (exp_img[1] / 4) % 4; g = exp_img[1] % 4;
    m = {g >= 2, r >= 2, c >= 2, ay >= 4, l >= 2, a >= 5};
    if (!mute_all_n) m = 6'h3F;
    return {3'(a), 3'(ay), 2'(l), 2'(c), 2'(r), 2'(g), 2'(exp_img[2] / 64), m,
            exp_img[2][5:1], exp_img[3][7:5], exp_img[4], exp_img[5][7:4]};
  endfunction

  function automatic logic [7:0] model_rb(int k);
    if (k >= 6) return 8'hFF;
    case (k)
      0: return exp_img[0] | 8'h03;
      2: return exp_img[2] | 8'h01;
      3: return exp_img[3] | 8'h1F;
      5: return {exp_img[5][7:4], fs1_lvl, fs2_lvl};
      default: return exp_img[k];
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    nack = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = nack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // Address plus n data bytes from wbuf; stop is left to the caller.
  task automatic write_open(int n);
    logic nk;
    bus_start();
    send_byte({7'b1001_000 | 7'(addr_pin), 1'b0}, nk);
    check("R1 write address ack", 64'(nk), 64'd0);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], nk);
      if (i < 6) check("R2 data byte ack", 64'(nk), 64'd0);
      else       check("R7 extra byte nack", 64'(nk), 64'd1);
    end
  endtask

  task automatic commit_model(int n);
    for (int i = 0; i < n && i < 6; i++) exp_img[i] = wbuf[i];
  endtask

  task automatic write_regs(int n, string req);
    write_open(n); bus_stop(); commit_model(n);
    check(req, 64'(dut_vec), 64'(model_vec()));
  endtask

  task automatic read_check(int n, string req);
    logic nk;
    bus_start();
    send_byte({7'b1001_000 | 7'(addr_pin), 1'b1}, nk);
    check("R1 read address ack", 64'(nk), 64'd0);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i == n - 1);
    bus_stop();
    for (int i = 0; i < n; i++) check(req, 64'(rbuf[i]), 64'(model_rb(i)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic nk;
    logic [7:0] rb;
    exp_img = '{8'h20, 8'h05, 8'h00, 8'h00, 8'h09, 8'h00};
    tick(5); rst_n = 1'b1; tick(5);

    // R4: reset state at the ports and through read-back (R5, R6)
    check("R4 reset outputs", 64'(dut_vec), 64'(model_vec()));
    check("R4 audio-switch reset 1001", 64'(asw_o), 64'h9);
    check("R11 idle line released", 64'(sda_pull_o), 64'd0);
    read_check(6, "R5 R6 reset read-back");

    // R1: sweep every address byte with pin low, matching region with pin high
    for (int p = 0; p < 2; p++) begin
      addr_pin = p[0];
      for (int a = 0; a < 256; a++) begin
        if (p == 1 && a[7:4] != 4'h9) continue;
        bus_start();
        send_byte(8'(a), nk);
        check("R1 address ack sweep", 64'(nk), 64'(a[7:1] != {6'b100100, p[0]}));
        if (nk == 1'b0 && a[0]) recv_byte(rb, 1'b1);
        bus_stop();
      end
    end
    addr_pin = 1'b0;
    check("R1 no change after sweep", 64'(dut_vec), 64'(model_vec()));

    // R3: full write held pending until stop; R10 field decode after it
    wbuf = '{8'h6C, 8'hA6, 8'hB6, 8'hE0, 8'h5A, 8'hD0, 8'h00, 8'h00};
    write_open(6);
    check("R3 pending write invisible", 64'(dut_vec), 64'(model_vec()));
    bus_stop(); commit_model(6);
    check("R3 R10 committed fields", 64'(dut_vec), 64'(model_vec()));
    read_check(6, "R5 R6 read-back after write");

    // R9: exhaustive AD and AUX CVBS/Y codes
    for (int c = 0; c < 8; c++) begin
      wbuf[0] = {3'(c), 3'(7 - c), 2'b00};
      write_regs(1, "R9 R10 AD/AUX code sweep");
    end
    // R9: two-bit path codes
    for (int v = 0; v < 16; v++) begin
      wbuf[0] = 8'h20; wbuf[1] = 8'(v * 17);
      write_regs(2, "R9 two-bit path sweep");
    end

    // R9: all-mute override and release
    mute_all_n = 1'b0; tick(2);
    check("R9 all-mute forces mute", 64'(path_mute), 64'h3F);
    check("R9 all-mute other fields", 64'(dut_vec), 64'(model_vec()));
    mute_all_n = 1'b1; tick(2);
    check("R9 all-mute released", 64'(dut_vec), 64'(model_vec()));

    // R7: seventh byte ignored, read past end gives FF
    wbuf = '{8'h84, 8'h5A, 8'h48, 8'h40, 8'hF0, 8'hE0, 8'h33, 8'h00};
    write_regs(7, "R7 seventh byte ignored");
    read_check(7, "R7 R5 read past last byte");

    // R8: repeated start restarts byte position
    wbuf[0] = 8'h44; write_open(1);
    wbuf[0] = 8'h88; write_open(1);
    bus_stop(); commit_model(1);
    check("R8 repeated start position 0", 64'(dut_vec), 64'(model_vec()));

    // R6: live monitor levels in the last byte
    fs1_lvl = 2'b11; fs2_lvl = 2'b00;
    read_check(6, "R6 live FS status");
    fs1_lvl = 2'b00; fs2_lvl = 2'b10;
    read_check(6, "R6 live FS status second");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule